// File: doc/BRIEF.md
# Receive Frame Error Classifier

The classifier sits beside a 256-bit receive packet stream and produces a judgement on each frame. Each beat carries 32 byte lanes. The first byte of a frame sits in the most significant lane of the start-of-packet beat. On the closing beat, the empty count gives the number of unused low-order lanes. Each lane also has a control flag and a terminate flag, and a CRC-check result comes with the end-of-packet beat.

From the beats it accepts, the block measures the frame length, which includes the 4-byte FCS. It checks that length against a runt window and a programmable upper limit. It also compares the payload size with the length/type field and watches for stray control characters. One cycle after the closing beat, it presents a six-bit cause vector together with an FCS-valid/FCS-error pair. Sequences of 8 bytes or fewer are not treated as frames and produce no report. CRC computation, line decoding and flow control are handled elsewhere.

Top module: `rx_frame_classifier`

## Requirements
- R1: Frame length is 32 times the number of beats accepted before the closing beat, plus 32 minus `in_empty` on the closing beat. This holds when start and end share one beat. Lane i is `in_data[8i+7:8i]`, and lane 31 holds the earliest byte.
- R2: `o_fcs_valid` is high for exactly one cycle, in the cycle after an accepted end-of-packet beat of a frame longer than 8 bytes. Whenever `o_fcs_valid` is low, `o_err` and `o_fcs_error` are zero.
- R3: A frame of 8 bytes or fewer produces no report and no runt CRC error.
- R4: A frame of 9 to 63 bytes inclusive sets `o_err[2]` (undersized) and also forces `o_err[1]`.
- R5: `o_err[1]` is set when `in_crc_bad` is high on the closing beat or the frame is a runt. `o_fcs_error` always equals `o_err[1]`.
- R6: `o_err[3]` (oversized) is set when the length is strictly greater than `cfg_max_len`, sampled on the closing beat.
- R7: `o_err[4]` (length error) is set when all of the following hold: `cfg_len_chk_en` is 1, the length is at least 64, and the length/type field is below 1536. The field is frame bytes 12–13, found at `in_data[159:144]` of the start beat with byte 12 in the high half. The payload is the length minus 18. The bit is set when the payload differs from the field, except that a 46-byte payload is accepted when the field is 46 or less.
- R8: `o_err[0]` (malformed) is set when any accepted beat of the frame has a lane with `in_ctrl` high and `in_term` low.
- R9: A valid beat outside a frame, meaning one with no start-of-packet while no frame is open, is ignored. It produces no report and does not affect the next frame.
- R10: A start-of-packet while a frame is open abandons that frame and restarts the length count. The next report then has `o_err[0]` set.
- R11: `o_err[5]` is always zero.
- R12: During and after reset, all outputs are zero and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 5 | Unused low lanes on the last beat |
| in_data | input | 256 | Beat bytes, earliest in the top lane |
| in_ctrl | input | 32 | Per-lane control-character flag |
| in_term | input | 32 | Per-lane terminate flag |
| in_crc_bad | input | 1 | CRC check failed, read on the last beat |
| cfg_max_len | input | 16 | Largest accepted frame length in bytes |
| cfg_len_chk_en | input | 1 | Enables the length/type comparison |
| o_fcs_valid | output | 1 | Report strobe |
| o_fcs_error | output | 1 | CRC-class error for the reported frame |
| o_err | output | 6 | Cause vector: malformed, CRC, undersized, oversized, length, reserved |

## Verification
The assertions assume that `in_empty` is zero on every non-closing beat, and that `cfg_max_len` and `cfg_len_chk_en` stay still while a frame is open. The assertion relating undersize and oversize also assumes that the limit is at least 64. The stimulus meets these assumptions by writing configuration only between frames, choosing limits from 64 upward and driving empty lanes only on the final beat. Stray beats and aborted frames are injected on purpose, because the design defines how both are handled.

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier #(
  parameter int DW      = 256,
  parameter int LENW    = 16,
  parameter int MINLEN  = 64,
  parameter int NOFRAME = 8,
  parameter int TYPEMIN = 1536,
  parameter int PADLEN  = 46,
  parameter int OVERHD  = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic [$clog2(DW/8)-1:0]  in_empty,
  input  logic [DW-1:0]            in_data,
  input  logic [DW/8-1:0]          in_ctrl,
  input  logic [DW/8-1:0]          in_term,
  input  logic                     in_crc_bad,
  input  logic [LENW-1:0]          cfg_max_len,
  input  logic                     cfg_len_chk_en,
  output logic                     o_fcs_valid,
  output logic                     o_fcs_error,
  output logic [5:0]               o_err
);
  localparam int NB = DW / 8;
  localparam int FPOS = DW - 97;
  localparam logic [LENW-1:0] L_MIN  = LENW'(MINLEN);
  localparam logic [LENW-1:0] L_NOFR = LENW'(NOFRAME);
  localparam logic [LENW-1:0] L_TYPE = LENW'(TYPEMIN);
  localparam logic [LENW-1:0] L_PAD  = LENW'(PADLEN);
  localparam logic [LENW-1:0] L_OVH  = LENW'(OVERHD);

  logic            active, bad_q;
  logic [LENW-1:0] acc_q, field_q;

  wire take  = in_valid && (in_sop || active);
  wire abort = in_valid && in_sop && active;
  wire hit   = |(in_ctrl & ~in_term);

  wire [LENW-1:0] base  = in_sop ? '0 : acc_q;
  wire [LENW-1:0] field = in_sop ? in_data[FPOS -: 16] : field_q;
  wire            bad   = abort || (!in_sop && bad_q) || hit;

  wire [LENW:0] sum = {1'b0, base} + (LENW+1)'(NB) - (LENW+1)'(in_empty);
  wire [LENW-1:0] len = sum[LENW] ? '1 : sum[LENW-1:0];

  wire [LENW-1:0] payload = len - L_OVH;
  wire is_frame = len > L_NOFR;
  wire runt     = is_frame && len < L_MIN;
  wire over     = len > cfg_max_len;
  wire len_err  = cfg_len_chk_en && !(len < L_MIN) && field < L_TYPE &&
                  !(field == payload || (field <= L_PAD && payload == L_PAD));
  wire crc_err  = in_crc_bad || runt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      bad_q       <= 1'b0;
      acc_q       <= '0;
      field_q     <= '0;
      o_fcs_valid <= 1'b0;
      o_fcs_error <= 1'b0;
      o_err       <= '0;
    end else begin
      o_fcs_valid <= 1'b0;
      o_fcs_error <= 1'b0;
      o_err       <= '0;
      if (take) begin
        if (in_eop) begin
          active <= 1'b0;
          if (is_frame) begin
            o_fcs_valid <= 1'b1;
            o_fcs_error <= crc_err;
            o_err       <= {1'b0, len_err, over, runt, crc_err, bad};
          end
        end else begin
          active  <= 1'b1;
          acc_q   <= len;
          field_q <= field;
          bad_q   <= bad;
        end
      end
    end
  end

  assert_report_follows_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    o_fcs_valid |-> $past(in_valid && in_eop));
  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !o_fcs_valid |-> (o_err == 6'd0 && !o_fcs_error));
  assert_runt_forces_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_fcs_valid && o_err[2]) |-> o_err[1]);
  assert_fcs_error_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    o_fcs_valid |-> (o_fcs_error == o_err[1]));
  assert_size_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_fcs_valid && $past(cfg_max_len) >= L_MIN) |-> !(o_err[2] && o_err[3]));
  assert_stray_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sop && !active) |=> !o_fcs_valid);
  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !o_err[5]);
endmodule

// File: tb/rx_frame_classifier_tb_top.sv
`timescale 1ns/1ps
module rx_frame_classifier_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_crc_bad = 0, cfg_len_chk_en = 0;
  logic [4:0] in_empty = 0;
  logic [255:0] in_data = 0;
  logic [31:0] in_ctrl = 0, in_term = 0;
  logic [15:0] cfg_max_len = 16'd1518;
  logic o_fcs_valid, o_fcs_error;
  logic [5:0] o_err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rx_frame_classifier dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_empty(in_empty), .in_data(in_data), .in_ctrl(in_ctrl),
    .in_term(in_term), .in_crc_bad(in_crc_bad), .cfg_max_len(cfg_max_len),
    .cfg_len_chk_en(cfg_len_chk_en), .o_fcs_valid(o_fcs_valid), .o_fcs_error(o_fcs_error),
    .o_err(o_err));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_err(int len, int field, bit crc, bit bad);
    bit runt = len > 8 && len < 64;
    int pay = len - 18;
    bit lerr = cfg_len_chk_en && len >= 64 && field < 1536 &&
               !(field == pay || (field <= 46 && pay == 46));
    return {1'b0, lerr, len > int'(cfg_max_len), runt, crc || runt, bad};
  endfunction

  task automatic send(int len, int field, bit crc, int bad_beat, bit pre_bad, string req);
    int nb = (len + 31) / 32;
    logic [5:0] e = exp_err(len, field, crc, bad_beat >= 0 || pre_bad);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (b == 0); in_eop = (b == nb - 1);
      in_data = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (b == 0) in_data[159:144] = 16'(field);
      in_empty = (b == nb - 1) ? 5'(nb * 32 - len) : 5'd0;
      in_ctrl = 0; in_term = 0;
      if (b == bad_beat) in_ctrl[$urandom_range(31, 0)] = 1'b1;
      if (b == nb - 1) begin in_ctrl[0] = 1'b1; in_term[0] = 1'b1; end
      in_crc_bad = (b == nb - 1) ? crc : 1'b0;
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; in_ctrl = 0; in_term = 0; in_crc_bad = 0;
    if (len <= 8) chk({req, " R3 no report"}, {7'd0, o_fcs_valid}, 8'd0);
    else begin
      chk({req, " R2 strobe"}, {7'd0, o_fcs_valid}, 8'd1);
      chk({req, " R1 R4 R6 R7 R8 vector"}, {2'd0, o_err}, {2'd0, e});
      chk({req, " R5 fcs error"}, {7'd0, o_fcs_error}, {7'd0, e[1]});
    end
    @(negedge clk);
    chk({req, " R2 single pulse"}, {1'b0, o_fcs_valid, o_err}, 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {1'b0, o_fcs_valid, o_err}, 8'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 after reset", {1'b0, o_fcs_valid, o_err}, 8'd0);

    cfg_len_chk_en = 1; cfg_max_len = 16'd100;
    send(8, 0, 0, -1, 0, "len8");
    send(1, 0, 1, -1, 0, "len1");
    send(9, 0, 0, -1, 0, "len9 runt");
    send(32, 14, 0, -1, 0, "len32 sop+eop");
    send(63, 45, 0, -1, 0, "len63 runt");
    send(64, 46, 0, -1, 0, "len64 exact");
    send(64, 20, 0, -1, 0, "R7 padded ok");
    send(64, 47, 0, -1, 0, "R7 mismatch");
    send(80, 1536, 0, -1, 0, "R7 type field");
    send(100, 82, 0, -1, 0, "R6 at max");
    send(101, 83, 0, -1, 0, "R6 over max");
    cfg_len_chk_en = 0;
    send(80, 5, 1, -1, 0, "R7 disabled crc");
    send(96, 78, 0, 1, 0, "R8 ctrl mid");

    @(negedge clk);
    in_valid = 1; in_eop = 1; in_ctrl = 32'h10; in_empty = 5'd3;
    @(negedge clk);
    in_valid = 0; in_eop = 0; in_ctrl = 0; in_empty = 0;
    chk("R9 stray beat", {7'd0, o_fcs_valid}, 8'd0);
    send(70, 52, 0, -1, 0, "R9 after stray");

    cfg_len_chk_en = 1;
    @(negedge clk);
    in_valid = 1; in_sop = 1;
    @(negedge clk);
    in_valid = 0; in_sop = 0;
    chk("R10 no report on abort", {7'd0, o_fcs_valid}, 8'd0);
    send(70, 52, 0, -1, 1, "R10 abort");
    send(70, 52, 0, -1, 0, "R10 clean after");

    for (int i = 0; i < 60; i++) begin
      int len = $urandom_range(200, 1);
      int field = ($urandom_range(1, 0) == 1) ? len - 18 : $urandom_range(1600, 0);
      cfg_len_chk_en = 1'($urandom_range(1, 0));
      cfg_max_len = 16'($urandom_range(220, 64));
      send(len, field, 1'($urandom_range(3, 0) == 0),
           ($urandom_range(4, 0) == 0) ? 0 : -1, 0, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule